// File: doc/BRIEF.md
# Command Queue Pair Engine

This block is the device end of a single command queue pair shared with a host. The host fills a submission ring in its own memory and announces new work by writing the new submission tail index to a doorbell. The engine notices that its submission head trails the tail. It then issues one read request for the 64-byte entry at the head, collects the returned 32-bit beats, and offers the assembled command to a back-end stream. When the back-end accepts the command, the head moves forward.

Results come back from the back-end as an identifier and a status. For each one the engine writes an 8-byte completion entry into the completion ring in host memory, at the completion tail. The entry also carries a phase bit and the current submission head. A one-cycle interrupt pulse follows each accepted completion write. The host frees completion slots by writing a second doorbell. When the completion ring is full, the engine stops taking results. A doorbell value outside the ring is dropped and latches an error flag.

Top module: `qpair_engine`

## Requirements
- R1: After reset, rd_req_valid, cmd_valid, wr_valid, irq and doorbell_err are 0, res_ready is 1, all four ring indices are 0 and the phase bit is 1.
- R2: Ring indices are 16 bits wide, DEPTH may be 2 to 65536, and every index wraps from DEPTH-1 to 0. A fetch of submission slot s reads address SQ_BASE + 64*s. A completion for slot c is written to CQ_BASE + 8*c.
- R3: No read request is made while the submission head equals the submission tail. Work becomes visible only through a tail doorbell.
- R4: A fetch is one read request followed by 16 in-order 32-bit beats. Beat k lands in cmd_data[32k+31:32k]. At most one fetch is in flight, and no new request is made while a command waits on cmd_valid.
- R5: The submission head advances by one, with wrap, when the back-end accepts a command with cmd_valid and cmd_ready.
- R6: Completion word layout: bits 15:0 hold the result id, bits 30:16 the status, bit 31 the phase, bits 47:32 the submission head when the result was accepted, and bits 63:48 are zero. wr_addr and wr_data hold steady while wr_valid waits for wr_ready.
- R7: The phase bit written is 1 on the first pass through the completion ring and flips each time the completion tail wraps to 0.
- R8: irq is high for exactly the one cycle after a completion write handshake. It is never high before the write is accepted.
- R9: When completion tail + 1 (mod DEPTH) equals the completion head, res_ready is 0 and no write is made until a head doorbell frees a slot.
- R10: A doorbell value >= DEPTH changes no index and sets doorbell_err, which stays set until reset.
- R11: db_sel = 0 writes the submission tail and db_sel = 1 writes the completion head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_valid | input | 1 | Doorbell write strobe |
| db_sel | input | 1 | 0: submission tail, 1: completion head |
| db_value | input | 16 | New index value |
| rd_req_valid | output | 1 | Entry read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Byte address of the entry |
| rd_beat_valid | input | 1 | Read data beat valid |
| rd_beat_data | input | 32 | Read data beat |
| cmd_valid | output | 1 | Command offered to back-end |
| cmd_ready | input | 1 | Back-end takes command |
| cmd_data | output | 512 | Whole command entry |
| res_valid | input | 1 | Back-end result valid |
| res_ready | output | 1 | Result accepted |
| res_cid | input | 16 | Result command identifier |
| res_status | input | 15 | Result status |
| wr_valid | output | 1 | Completion write valid |
| wr_ready | input | 1 | Completion write accepted |
| wr_addr | output | ADDR_W | Byte address of completion slot |
| wr_data | output | 64 | Completion entry |
| irq | output | 1 | Interrupt pulse |
| doorbell_err | output | 1 | Sticky bad-doorbell flag |

## Verification
A wrong submission head shows up on the very next fetch as a read address off by a multiple of 64 bytes. It also shows up in the head field of the next completion. A wrong completion tail or phase is visible at the next completion write, through the address and bit 31, and it surfaces as soon as the ring wraps. A miscounted beat index corrupts the command words the moment cmd_valid rises. A broken fullness test shows up as a write that lands while the host has not freed any slot.

// File: rtl/qpe_pkg.sv
package qpe_pkg;

    localparam int PTR_W   = 16;
    localparam int BEATS   = 16;
    localparam int BEAT_W  = 32;
    localparam int ENTRY_W = BEATS * BEAT_W;
    localparam int CID_W   = 16;
    localparam int STAT_W  = 15;
    localparam int CPL_W   = 64;

    typedef enum logic [1:0] {
        F_IDLE,
        F_REQ,
        F_BEATS,
        F_HOLD
    } fetch_st_e;

    typedef enum logic {
        C_IDLE,
        C_WRITE
    } cpl_st_e;

    typedef struct packed {
        logic [15:0]       zero;
        logic [PTR_W-1:0]  sq_head;
        logic              phase;
        logic [STAT_W-1:0] status;
        logic [CID_W-1:0]  cid;
    } cpl_entry_t;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p,
                                                 input logic [PTR_W-1:0] last);
        return (p == last) ? '0 : p + 1'b1;
    endfunction

endpackage

// File: rtl/qpe_doorbell.sv
module qpe_doorbell
    import qpe_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             db_valid,
    input  logic             db_sel,
    input  logic [PTR_W-1:0] db_value,
    output logic [PTR_W-1:0] sq_tail,
    output logic [PTR_W-1:0] cq_head,
    output logic             err
);

    typedef struct packed {
        logic [PTR_W-1:0] sq_tail;
        logic [PTR_W-1:0] cq_head;
        logic             err;
    } db_state_t;

    db_state_t s_d, s_q;
    logic      out_of_range;

    always_comb begin
        s_d          = s_q;
        out_of_range = (32'(db_value) >= DEPTH);
        if (db_valid) begin
            if (out_of_range) begin
                s_d.err = 1'b1;
            end else if (db_sel) begin
                s_d.cq_head = db_value;
            end else begin
                s_d.sq_tail = db_value;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sq_tail = s_q.sq_tail;
    assign cq_head = s_q.cq_head;
    assign err     = s_q.err;

endmodule

// File: rtl/qpe_fetch.sv
module qpe_fetch
    import qpe_pkg::*;
#(
    parameter int                DEPTH   = 16,
    parameter int                ADDR_W  = 32,
    parameter logic [ADDR_W-1:0] SQ_BASE = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PTR_W-1:0]   sq_tail,
    output logic [PTR_W-1:0]   sq_head,
    output logic               rd_req_valid,
    input  logic               rd_req_ready,
    output logic [ADDR_W-1:0]  rd_req_addr,
    input  logic               rd_beat_valid,
    input  logic [BEAT_W-1:0]  rd_beat_data,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [ENTRY_W-1:0] cmd_data
);

    localparam int               CNT_W = $clog2(BEATS);
    localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

    typedef struct packed {
        fetch_st_e                    st;
        logic [PTR_W-1:0]             head;
        logic [CNT_W-1:0]             cnt;
        logic [ADDR_W-1:0]            addr;
        logic [BEATS-1:0][BEAT_W-1:0] ent;
    } fetch_state_t;

    fetch_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            F_IDLE: begin
                if (s_q.head != sq_tail) begin
                    s_d.st   = F_REQ;
                    s_d.addr = SQ_BASE + (ADDR_W'(s_q.head) << 6);
                end
            end
            F_REQ: begin
                if (rd_req_ready) begin
                    s_d.st  = F_BEATS;
                    s_d.cnt = '0;
                end
            end
            F_BEATS: begin
                if (rd_beat_valid) begin
                    s_d.ent[s_q.cnt] = rd_beat_data;
                    s_d.cnt          = s_q.cnt + 1'b1;
                    if (s_q.cnt == LAST_BEAT) begin
                        s_d.st = F_HOLD;
                    end
                end
            end
            F_HOLD: begin
                if (cmd_ready) begin
                    s_d.st   = F_IDLE;
                    s_d.head = ptr_inc(s_q.head, LAST);
                end
            end
            default: s_d.st = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: F_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign sq_head      = s_q.head;
    assign rd_req_valid = (s_q.st == F_REQ);
    assign rd_req_addr  = s_q.addr;
    assign cmd_valid    = (s_q.st == F_HOLD);
    assign cmd_data     = s_q.ent;

endmodule

// File: rtl/qpe_cpl.sv
module qpe_cpl
    import qpe_pkg::*;
#(
    parameter int                DEPTH   = 16,
    parameter int                ADDR_W  = 32,
    parameter logic [ADDR_W-1:0] CQ_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTR_W-1:0]  sq_head,
    input  logic [PTR_W-1:0]  cq_head,
    output logic [PTR_W-1:0]  cq_tail,
    input  logic              res_valid,
    output logic              res_ready,
    input  logic [CID_W-1:0]  res_cid,
    input  logic [STAT_W-1:0] res_status,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [CPL_W-1:0]  wr_data,
    output logic              irq
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        cpl_st_e           st;
        logic [PTR_W-1:0]  tail;
        logic              phase;
        logic [ADDR_W-1:0] addr;
        cpl_entry_t        ent;
        logic              irq;
    } cpl_state_t;

    cpl_state_t s_d, s_q;
    logic       ring_full;
    logic       take;

    always_comb begin
        s_d       = s_q;
        s_d.irq   = 1'b0;
        ring_full = (ptr_inc(s_q.tail, LAST) == cq_head);
        take      = (s_q.st == C_IDLE) && !ring_full && res_valid;
        unique case (s_q.st)
            C_IDLE: begin
                if (take) begin
                    s_d.st          = C_WRITE;
                    s_d.addr        = CQ_BASE + (ADDR_W'(s_q.tail) << 3);
                    s_d.ent.zero    = '0;
                    s_d.ent.sq_head = sq_head;
                    s_d.ent.phase   = s_q.phase;
                    s_d.ent.status  = res_status;
                    s_d.ent.cid     = res_cid;
                end
            end
            C_WRITE: begin
                if (wr_ready) begin
                    s_d.st   = C_IDLE;
                    s_d.irq  = 1'b1;
                    s_d.tail = ptr_inc(s_q.tail, LAST);
                    if (s_q.tail == LAST) begin
                        s_d.phase = ~s_q.phase;
                    end
                end
            end
            default: s_d.st = C_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: C_IDLE, phase: 1'b1, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cq_tail   = s_q.tail;
    assign res_ready = (s_q.st == C_IDLE) && !ring_full;
    assign wr_valid  = (s_q.st == C_WRITE);
    assign wr_addr   = s_q.addr;
    assign wr_data   = s_q.ent;
    assign irq       = s_q.irq;

endmodule

// File: rtl/qpair_engine.sv
module qpair_engine
    import qpe_pkg::*;
#(
    parameter int                DEPTH   = 16,
    parameter int                ADDR_W  = 32,
    parameter logic [ADDR_W-1:0] SQ_BASE = ADDR_W'(32'h0001_0000),
    parameter logic [ADDR_W-1:0] CQ_BASE = ADDR_W'(32'h0002_0000)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               db_valid,
    input  logic               db_sel,
    input  logic [15:0]        db_value,
    output logic               rd_req_valid,
    input  logic               rd_req_ready,
    output logic [ADDR_W-1:0]  rd_req_addr,
    input  logic               rd_beat_valid,
    input  logic [31:0]        rd_beat_data,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [511:0]       cmd_data,
    input  logic               res_valid,
    output logic               res_ready,
    input  logic [15:0]        res_cid,
    input  logic [14:0]        res_status,
    output logic               wr_valid,
    input  logic               wr_ready,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [63:0]        wr_data,
    output logic               irq,
    output logic               doorbell_err
);

    logic [PTR_W-1:0] sq_head;
    logic [PTR_W-1:0] sq_tail;
    logic [PTR_W-1:0] cq_head;
    logic [PTR_W-1:0] cq_tail;

    qpe_doorbell #(.DEPTH(DEPTH)) u_db (
        .clk      (clk),
        .rst_n    (rst_n),
        .db_valid (db_valid),
        .db_sel   (db_sel),
        .db_value (db_value),
        .sq_tail  (sq_tail),
        .cq_head  (cq_head),
        .err      (doorbell_err)
    );

    qpe_fetch #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SQ_BASE(SQ_BASE)) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .sq_tail       (sq_tail),
        .sq_head       (sq_head),
        .rd_req_valid  (rd_req_valid),
        .rd_req_ready  (rd_req_ready),
        .rd_req_addr   (rd_req_addr),
        .rd_beat_valid (rd_beat_valid),
        .rd_beat_data  (rd_beat_data),
        .cmd_valid     (cmd_valid),
        .cmd_ready     (cmd_ready),
        .cmd_data      (cmd_data)
    );

    qpe_cpl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CQ_BASE(CQ_BASE)) u_cpl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sq_head    (sq_head),
        .cq_head    (cq_head),
        .cq_tail    (cq_tail),
        .res_valid  (res_valid),
        .res_ready  (res_ready),
        .res_cid    (res_cid),
        .res_status (res_status),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .irq        (irq)
    );

endmodule

// File: rtl/qpe_chk.sv
module qpe_chk
    import qpe_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_req_valid,
    input logic             rd_req_ready,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic [63:0]      wr_data,
    input logic             irq,
    input logic             doorbell_err,
    input logic [PTR_W-1:0] sq_head,
    input logic [PTR_W-1:0] sq_tail,
    input logic [PTR_W-1:0] cq_head,
    input logic [PTR_W-1:0] cq_tail
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    initial begin
        p_depth_range_r2: assert (DEPTH >= 2 && DEPTH <= 65536)
            else $error("DEPTH out of range");
    end

    // R3: a request only while work is pending
    p_fetch_needs_work_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (sq_head != sq_tail));

    // R4: single fetch in flight
    p_one_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> !cmd_valid);

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> rd_req_valid);

    // R5: head moves only on command acceptance
    p_head_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sq_head) |-> $past(cmd_valid && cmd_ready));

    // R6: completion held until accepted
    p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));

    // R8: interrupt only after an accepted write
    p_irq_after_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(wr_valid && wr_ready));

    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9: never write into a full ring
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (ptr_inc(cq_tail, LAST) != cq_head));

    // R10: error flag is sticky
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        doorbell_err |=> doorbell_err);

endmodule

bind qpair_engine qpe_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_data      (wr_data),
    .irq          (irq),
    .doorbell_err (doorbell_err),
    .sq_head      (sq_head),
    .sq_tail      (sq_tail),
    .cq_head      (cq_head),
    .cq_tail      (cq_tail)
);

// File: tb/qpair_engine_tb_top.sv
`timescale 1ns/1ps
module qpair_engine_tb_top;

    localparam int          DEPTH   = 4;
    localparam logic [31:0] SQ_BASE = 32'h0001_0000;
    localparam logic [31:0] CQ_BASE = 32'h0002_0000;
    localparam int          NVEC    = 10;

    // word0 of expected completion: {phase, status, cid}
    localparam logic [31:0] VEC [NVEC] = '{
        32'h8000_0101, 32'h8001_0102, 32'hFFFF_0103, 32'h8042_0104,
        32'h0000_0205, 32'h7FFF_0206, 32'h0123_0207, 32'h0000_FFFF,
        32'h8005_0309, 32'h8000_0000
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         db_valid, db_sel;
    logic [15:0]  db_value;
    logic         rd_req_valid, rd_req_ready;
    logic [31:0]  rd_req_addr;
    logic         rd_beat_valid;
    logic [31:0]  rd_beat_data;
    logic         cmd_valid, cmd_ready;
    logic [511:0] cmd_data;
    logic         res_valid, res_ready;
    logic [15:0]  res_cid;
    logic [14:0]  res_status;
    logic         wr_valid, wr_ready;
    logic [31:0]  wr_addr;
    logic [63:0]  wr_data;
    logic         irq, doorbell_err;

    int          n_total = 0;
    int          n_bad   = 0;
    bit          finished = 1'b0;
    logic [31:0] last_req_addr = '0;

    always #2 clk = ~clk;

    qpair_engine #(.DEPTH(DEPTH), .ADDR_W(32), .SQ_BASE(SQ_BASE), .CQ_BASE(CQ_BASE)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .db_valid(db_valid), .db_sel(db_sel), .db_value(db_value),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
        .rd_beat_valid(rd_beat_valid), .rd_beat_data(rd_beat_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .res_valid(res_valid), .res_ready(res_ready), .res_cid(res_cid), .res_status(res_status),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq(irq), .doorbell_err(doorbell_err)
    );

    function automatic logic [31:0] pat(input int slot, input int k);
        return {8'hC3, 8'(slot), 8'(k), 8'(slot * 16 + k)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    endtask

    // host memory: answers each request with 16 beats
    initial begin
        rd_beat_valid = 1'b0;
        rd_beat_data  = '0;
        forever begin
            @(negedge clk);
            if (rd_req_valid && rd_req_ready) begin
                last_req_addr = rd_req_addr;
                @(negedge clk);
                for (int k = 0; k < 16; k++) begin
                    rd_beat_valid = 1'b1;
                    rd_beat_data  = pat(int'((last_req_addr - SQ_BASE) >> 6), k);
                    @(negedge clk);
                end
                rd_beat_valid = 1'b0;
            end
        end
    end

    task automatic ring(input logic sel, input logic [15:0] v);
        @(negedge clk);
        db_valid = 1'b1;
        db_sel   = sel;
        db_value = v;
        @(negedge clk);
        db_valid = 1'b0;
    endtask

    task automatic take_cmd(input int slot);
        bit ok;
        for (int t = 0; t < 300 && !cmd_valid; t++) @(negedge clk);
        chk(cmd_valid, "R4 cmd_valid", 64'(cmd_valid), 64'd1);
        chk(last_req_addr == SQ_BASE + 32'(slot * 64), "R2 fetch address",
            64'(last_req_addr), 64'(SQ_BASE + 32'(slot * 64)));
        ok = 1'b1;
        for (int k = 0; k < 16; k++) begin
            if (cmd_data[32*k +: 32] != pat(slot, k)) ok = 1'b0;
        end
        chk(ok, "R4 beat order", 64'(cmd_data[511:480]), 64'(pat(slot, 15)));
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
    endtask

    task automatic give_res(input logic [15:0] cid, input logic [14:0] st);
        res_valid  = 1'b1;
        res_cid    = cid;
        res_status = st;
        for (int t = 0; t < 300 && !res_ready; t++) @(negedge clk);
        chk(res_ready, "R9 res_ready", 64'(res_ready), 64'd1);
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic take_cpl(input int cslot, input logic [31:0] w0, input logic [15:0] sqh,
                            input bit hold);
        logic [63:0] exp;
        bit          ok;
        exp = {16'h0, sqh, w0};
        for (int t = 0; t < 300 && !wr_valid; t++) @(negedge clk);
        chk(wr_addr == CQ_BASE + 32'(cslot * 8), "R2 completion address",
            64'(wr_addr), 64'(CQ_BASE + 32'(cslot * 8)));
        chk(wr_data == exp, "R6 R7 completion entry", wr_data, exp);
        if (hold) begin
            ok = 1'b1;
            for (int t = 0; t < 3; t++) begin
                @(negedge clk);
                if (irq || !wr_valid || wr_data != exp) ok = 1'b0;
            end
            chk(ok, "R8 no irq before write accepted", 64'(irq), 64'd0);
        end
        wr_ready = 1'b1;
        @(negedge clk);
        wr_ready = 1'b0;
        chk(irq == 1'b1 && !wr_valid, "R8 irq after write", 64'(irq), 64'd1);
        @(negedge clk);
        chk(irq == 1'b0, "R8 irq one cycle", 64'(irq), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_total++;
            n_bad++;
            $display("FAIL watchdog expired act=running exp=done");
            summary();
            $finish;
        end
    end

    initial begin
        bit ok;
        rst_n = 1'b0; db_valid = 1'b0; db_sel = 1'b0; db_value = '0;
        rd_req_ready = 1'b1; cmd_ready = 1'b0; res_valid = 1'b0;
        res_cid = '0; res_status = '0; wr_ready = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!rd_req_valid && !cmd_valid && !wr_valid, "R1 idle outputs",
            {61'd0, rd_req_valid, cmd_valid, wr_valid}, 64'd0);
        chk(!irq && !doorbell_err, "R1 irq/err", {62'd0, irq, doorbell_err}, 64'd0);
        chk(res_ready, "R1 res_ready", 64'(res_ready), 64'd1);

        // R3 nothing fetched without a doorbell
        ok = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (rd_req_valid) ok = 1'b0;
        end
        chk(ok, "R3 no fetch before doorbell", 64'(rd_req_valid), 64'd0);

        // vector table: one command per row, wraps both rings twice (R5 R7 R11)
        for (int i = 0; i < NVEC; i++) begin
            ring(1'b0, 16'((i + 1) % DEPTH));
            take_cmd(i % DEPTH);
            give_res(VEC[i][15:0], VEC[i][30:16]);
            take_cpl(i % DEPTH, VEC[i], 16'((i + 1) % DEPTH), i == 0);
            ring(1'b1, 16'((i + 1) % DEPTH));
        end

        // R9 fill the completion ring: head stays at 2
        ring(1'b0, 16'd1);
        for (int j = 0; j < 3; j++) begin
            take_cmd((2 + j) % DEPTH);
            give_res(16'(16'h0A00 + j), 15'(j));
            take_cpl((2 + j) % DEPTH, {(j < 2) ? 1'b1 : 1'b0, 15'(j), 16'(16'h0A00 + j)},
                     16'((3 + j) % DEPTH), 1'b0);
        end
        ring(1'b0, 16'd2);
        take_cmd(1);
        res_valid = 1'b1; res_cid = 16'h0B00; res_status = 15'h55;
        ok = 1'b1;
        repeat (8) begin
            @(negedge clk);
            if (res_ready || wr_valid) ok = 1'b0;
        end
        chk(ok, "R9 stall while full", {62'd0, res_ready, wr_valid}, 64'd0);
        ring(1'b1, 16'd1);
        give_res(16'h0B00, 15'h55);
        take_cpl(1, {1'b0, 15'h55, 16'h0B00}, 16'd2, 1'b0);

        // R10 out-of-range doorbells
        ring(1'b0, 16'(DEPTH));
        chk(doorbell_err, "R10 err set", 64'(doorbell_err), 64'd1);
        ring(1'b0, 16'hFFFF);
        ring(1'b1, 16'h0009);
        ok = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (rd_req_valid || wr_valid) ok = 1'b0;
        end
        chk(ok, "R10 bad tail ignored", 64'(rd_req_valid), 64'd0);
        ring(1'b0, 16'd3);
        take_cmd(2);
        give_res(16'h0C0C, 15'h1);
        take_cpl(2, {1'b0, 15'h1, 16'h0C0C}, 16'd3, 1'b0);
        chk(doorbell_err, "R10 err sticky", 64'(doorbell_err), 64'd1);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule